// File: doc/BRIEF.md
# One-Wire Ratio-Coded Command Transmitter

This block is the controller side of a single-wire command link. A host gives it a 9-bit brightness code, a flag that asks for an acknowledge and a bit period in clock cycles, then pulses a start request. The block builds a 24-bit frame that carries a fixed address. It drives the line high for a start interval and sends the frame least significant bit first.

Each bit begins with a falling edge and is one low phase followed by one high phase. The ratio between the two phases carries the value. A short low phase followed by a long high phase means 1. A long low phase followed by a short high phase means 0. After the last bit the line is held low for an end-of-stream interval.

When an acknowledge is asked for, the line is held low for a longer acknowledge-valid delay instead. The block then stops driving the line, so the line must be open-drain with a pull-up. It samples the line at a fixed point of the release window and waits until the window closes before it drives the line again. A high reading at the sample point raises a failure flag. A low reading means the receiver took the command.

Top module: `onewire_cmd_tx`

## Requirements
- R1: After reset, and whenever the block is idle, the line is driven high (`line_oe`=1, `line_out`=1), `busy` is 0 and `ack_fail` is 0 (the latter only after reset).
- R2: A start request seen while idle raises `busy` on the next cycle. The line is then driven high for exactly START_CYC cycles before the first falling edge.
- R3: The frame is sent least significant bit first and has this layout: bits 23..16 = 8'h8F, bits 15..11 = 0, bit 10 = acknowledge request, bit 9 = 0, bits 8..0 = brightness code.
- R4: With an effective period P and S = floor(P/3), a 1 bit is low for S cycles and then high for P-S cycles. A 0 bit is low for P-S cycles and then high for S cycles. Each bit begins with a falling edge.
- R5: The effective period is the `period` input clamped to the range P_MIN..P_MAX (9..90 in the bench). It is captured when the start request is accepted.
- R6: Without an acknowledge request, the last bit is followed by exactly EOS_CYC low cycles. The line is then driven high and `busy` is 0.
- R7: With an acknowledge request, the last bit is followed by exactly ACKV_CYC driven low cycles. The line is then released (`line_oe`=0) for exactly ACK_WIN cycles, then driven high, and `busy` drops.
- R8: During the release window, `line_in` is sampled ACK_SAMPLE cycles after the release begins. A high reading sets `ack_fail` to 1. A low reading leaves it at 0.
- R9: `ack_fail` keeps its value while idle. It is cleared only when the next start request is accepted.
- R10: Start requests made while `busy` is high are ignored. The frame in progress keeps the payload and period captured at its own start.
- R11: The line is released only during the acknowledge window. At all other times `line_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, accepted when idle |
| level | input | 9 | Brightness code to send |
| ack_req | input | 1 | Ask the receiver for an acknowledge |
| period | input | PW | Bit period in clock cycles, clamped |
| line_in | input | 1 | Sampled level of the line |
| line_out | output | 1 | Level driven onto the line |
| line_oe | output | 1 | Drive enable; 0 releases the line |
| busy | output | 1 | Command in progress |
| ack_fail | output | 1 | Acknowledge was requested and not seen |

## Verification
The bench decodes the line independently. It measures each low and high run, rebuilds the frame from the run ratios and compares every run length with the clamped period. A wrong shift position or bit index therefore shows as a wrong frame bit within one bit period. A wrong phase counter shows as a run of the wrong length on the very next edge. A state machine that leaves the acknowledge path at the wrong time shows as a driven cycle inside the release window or as a wrong end-of-stream length. A missed or stuck sample shows on `ack_fail` as soon as `busy` falls.

// File: rtl/onewire_cmd_tx.sv
module onewire_cmd_tx #(
  parameter int PW         = 16,
  parameter int P_MIN      = 625,
  parameter int P_MAX      = 58823,
  parameter int START_CYC  = 200,
  parameter int EOS_CYC    = 200,
  parameter int ACKV_CYC   = 1000,
  parameter int ACK_SAMPLE = 2000,
  parameter int ACK_WIN    = 51200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [8:0]    level,
  input  logic          ack_req,
  input  logic [PW-1:0] period,
  input  logic          line_in,
  output logic          line_out,
  output logic          line_oe,
  output logic          busy,
  output logic          ack_fail
);
  localparam int T1   = (START_CYC > EOS_CYC) ? START_CYC : EOS_CYC;
  localparam int T2   = (ACKV_CYC > ACK_WIN) ? ACKV_CYC : ACK_WIN;
  localparam int TMAX = (T1 > T2) ? T1 : T2;
  localparam int CW   = ($clog2(TMAX + 1) > PW) ? $clog2(TMAX + 1) : PW;
  localparam logic [7:0] ADDR = 8'h8F;

  typedef enum logic [2:0] {S_IDLE, S_START, S_LO, S_HI, S_EOS, S_ACKV, S_REL} st_t;

  st_t            st;
  logic [CW-1:0]  cnt, short_q, long_q;
  logic [23:0]    sh;
  logic [4:0]     idx;
  logic           ackq;
  logic [PW-1:0]  pc;

  always_comb begin
    if (period < PW'(P_MIN))      pc = PW'(P_MIN);
    else if (period > PW'(P_MAX)) pc = PW'(P_MAX);
    else                          pc = period;
  end

  assign busy     = (st != S_IDLE);
  assign line_oe  = (st != S_REL);
  assign line_out = (st == S_IDLE) || (st == S_START) || (st == S_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      short_q  <= '0;
      long_q   <= '0;
      sh       <= '0;
      idx      <= '0;
      ackq     <= 1'b0;
      ack_fail <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          sh       <= {ADDR, 5'b0, ack_req, 1'b0, level};
          ackq     <= ack_req;
          short_q  <= CW'(pc / PW'(3));
          long_q   <= CW'(pc - pc / PW'(3));
          ack_fail <= 1'b0;
          idx      <= '0;
          cnt      <= CW'(START_CYC - 1);
          st       <= S_START;
        end
        S_START: if (cnt == '0) begin
          cnt <= sh[0] ? short_q - 1'b1 : long_q - 1'b1;
          st  <= S_LO;
        end else cnt <= cnt - 1'b1;
        S_LO: if (cnt == '0) begin
          cnt <= sh[0] ? long_q - 1'b1 : short_q - 1'b1;
          st  <= S_HI;
        end else cnt <= cnt - 1'b1;
        S_HI: if (cnt == '0) begin
          if (idx == 5'd23) begin
            cnt <= ackq ? CW'(ACKV_CYC - 1) : CW'(EOS_CYC - 1);
            st  <= ackq ? S_ACKV : S_EOS;
          end else begin
            idx <= idx + 1'b1;
            sh  <= sh >> 1;
            cnt <= sh[1] ? short_q - 1'b1 : long_q - 1'b1;
            st  <= S_LO;
          end
        end else cnt <= cnt - 1'b1;
        S_EOS: if (cnt == '0) st <= S_IDLE;
               else cnt <= cnt - 1'b1;
        S_ACKV: if (cnt == '0) begin
          cnt <= CW'(ACK_WIN - 1);
          st  <= S_REL;
        end else cnt <= cnt - 1'b1;
        S_REL: begin
          if (cnt == CW'(ACK_WIN - 1 - ACK_SAMPLE) && line_in) ack_fail <= 1'b1;
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/onewire_cmd_tx_chk.sv
module onewire_cmd_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic line_out,
  input logic line_oe,
  input logic ack_fail
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (line_oe && line_out));

  p_busy_by_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_release_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> busy);

  p_release_after_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> !$past(line_out));

  p_fail_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_fail) |-> (busy && !line_oe));

  p_fail_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_fail) |-> ($past(start) && !$past(busy)));
endmodule

bind onewire_cmd_tx onewire_cmd_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .line_out(line_out), .line_oe(line_oe), .ack_fail(ack_fail)
);

// File: tb/onewire_cmd_tx_tb.sv
module onewire_cmd_tx_tb;
  localparam int PW = 16, PMIN = 9, PMAX = 90;
  localparam int SC = 8, EC = 6, AV = 10, AS = 4, AW = 20;
  localparam int NV = 7;
  localparam logic [27:0] VEC [NV] = '{
    {9'h000, 1'b0, 16'd9,   1'b0, 1'b0},
    {9'h1FF, 1'b0, 16'd12,  1'b0, 1'b0},
    {9'h155, 1'b1, 16'd10,  1'b1, 1'b0},
    {9'h0AA, 1'b1, 16'd15,  1'b0, 1'b0},
    {9'h123, 1'b0, 16'd3,   1'b0, 1'b0},
    {9'h0F0, 1'b0, 16'd200, 1'b0, 1'b0},
    {9'h03C, 1'b0, 16'd11,  1'b0, 1'b1}
  };

  logic clk = 0, rst_n = 0, start = 0, ack_req = 0, slave = 0;
  logic [8:0] level = '0;
  logic [PW-1:0] period = '0;
  logic line_in, line_out, line_oe, busy, ack_fail;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;
  assign line_in = line_oe ? line_out : ~slave;

  onewire_cmd_tx #(.PW(PW), .P_MIN(PMIN), .P_MAX(PMAX), .START_CYC(SC), .EOS_CYC(EC),
                   .ACKV_CYC(AV), .ACK_SAMPLE(AS), .ACK_WIN(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .level(level), .ack_req(ack_req),
    .period(period), .line_in(line_in), .line_out(line_out), .line_oe(line_oe),
    .busy(busy), .ack_fail(ack_fail));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [8:0] lv, input logic ak, input int per,
                         input logic resp, input logic inj, input logic expf);
    int pe, s, l, n, lo, hi, lenerr;
    logic [23:0] fr, ef;
    pe = (per < PMIN) ? PMIN : (per > PMAX) ? PMAX : per;
    s = pe / 3; l = pe - s; lenerr = 0;
    ef = {8'h8F, 5'b0, ak, 1'b0, lv};
    @(negedge clk);
    level = lv; ack_req = ak; period = PW'(per); start = 1; slave = resp;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    n = 0;
    while (line_oe && line_out) begin n++; @(negedge clk); end
    chk(n == SC, "R2 start high length", n, SC);
    for (int b = 0; b < 24; b++) begin
      lo = 0;
      while (line_oe && !line_out) begin
        if (inj && b == 3 && lo == 0) begin
          start = 1; level = ~lv; ack_req = ~ak; period = PW'(PMAX);
        end else start = 0;
        lo++; @(negedge clk);
      end
      start = 0;
      hi = 0;
      while (line_oe && line_out) begin hi++; @(negedge clk); end
      fr[b] = (hi > lo);
      if (fr[b] ? (lo != s || hi != l) : (lo != l || hi != s)) lenerr++;
    end
    level = lv; ack_req = ak;
    chk(fr == ef, inj ? "R10 frame kept while busy" : "R3 frame content", int'(fr), int'(ef));
    chk(lenerr == 0, "R4 R5 phase lengths", lenerr, 0);
    n = 0;
    while (line_oe && !line_out) begin n++; @(negedge clk); end
    if (ak) begin
      chk(n == AV, "R7 ack-valid low length", n, AV);
      n = 0;
      while (!line_oe) begin n++; @(negedge clk); end
      chk(n == AW, "R7 release window length", n, AW);
    end else begin
      chk(n == EC, "R6 end-of-stream length", n, EC);
    end
    chk(busy == 1'b0 && line_oe && line_out, "R6 R7 R11 idle after command", int'(busy), 0);
    chk(ack_fail == expf, "R8 ack result", int'(ack_fail), int'(expf));
    slave = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && line_oe == 1 && line_out == 1 && ack_fail == 0, "R1 reset state",
        int'({busy, line_oe, line_out, ack_fail}), 6);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      run_cmd(v[27:19], v[18], int'(v[17:2]), v[1], v[0], v[18] & ~v[1]);
    end
    run_cmd(9'h011, 1'b1, 20, 1'b0, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    chk(ack_fail == 1'b1, "R9 ack_fail holds while idle", int'(ack_fail), 1);
    chk(line_oe && line_out && !busy, "R1 idle line high", int'({line_oe, line_out}), 3);
    run_cmd(9'h0C3, 1'b0, 9, 1'b0, 1'b0, 1'b0);
    chk(ack_fail == 1'b0, "R9 cleared by next start", int'(ack_fail), 0);
    @(negedge clk);
    level = 9'h1AB; ack_req = 1; period = 16'd9; start = 1;
    @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(!busy && line_oe && line_out && !ack_fail, "R1 reset mid-frame",
        int'({busy, line_oe, line_out, ack_fail}), 6);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!busy && line_oe && line_out, "R1 stays idle without start", int'(busy), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule